// File: doc/BRIEF.md
# PCI Memory Target Sequencer

This block answers memory transactions on a 32-bit PCI bus as a target. It never requests the bus and never starts a transaction. A separate configuration block supplies the upper address bits of a 1 MB window. Any memory read or memory write whose address falls inside that window is claimed. Each data phase is handed to a back-end core as a single start strobe. The strobe carries the word-aligned 20-bit byte offset inside the window, the active-low byte enables and, for writes, the data taken from the bus. The core finishes the access with a one-clock done pulse, which may come any number of clocks later.

Bursts are supported with linear addressing: each later data phase uses an offset four bytes above the one before it. The next offset is held in a register ahead of time, so it is ready at the edge where a phase completes. The window and command match is registered on every clock, whether or not that clock is an address phase. The sequencer then only tests a stored bit one clock later. An abort timer limits how long the first data phase may wait on the core. When it runs out, the target requests a retry.

Top module: `memtgt_seq`

## Requirements
- R1: While rst_n is low and after its release with no transaction, trdy_n, devsel_n and stop_n are high, ad_oe is low and neither start strobe is high.
- R2: A transaction is claimed when, in its address phase, cbe_n is 4'b0110 (memory read) or 4'b0111 (memory write), ad_in[31:20] equals bar_base and ad_in[1:0] is 2'b00. devsel_n stays high at the first clock edge after the address phase and is low after the second.
- R3: An address phase with ad_in[31:20] not equal to bar_base, or with any other command code, leaves devsel_n and trdy_n high and issues no core strobe.
- R4: Each data phase of a claimed transaction raises exactly one one-clock strobe: core_wr_start for a write, core_rd_start for a read. The strobe carries core_addr equal to the phase offset, core_be_n equal to cbe_n of that phase and, for writes, core_wdata equal to ad_in of that phase.
- R5: trdy_n goes low in the clock right after the one in which core_done was high, and stays low for one clock when irdy_n is low. In a read, ad_out holds the core_rdata value returned with that done.
- R6: In a burst, data phase i uses offset (start offset + 4*i) modulo 2^20, so the offset after 0xFFFFC is 0x00000.
- R7: A data phase that completes with frame_n high ends the transaction: after that edge devsel_n is high and the block accepts a new address phase.
- R8: ad_oe is low in the turnaround clock after the address phase. It is high from the next clock until the end of a read transaction, and it is never high during a write.
- R9: If the first data phase has not completed ABORT_LIMIT+1 clocks after devsel_n went low, stop_n goes low with trdy_n high. stop_n and devsel_n return high at the edge that samples frame_n high.
- R10: A core_done pulse while no data phase is waiting on the core has no effect: trdy_n, devsel_n and stop_n stay high.
- R11: While irdy_n is high, no core strobe is issued.
- R12: An address phase with ad_in[1:0] not equal to 2'b00 (a non-linear burst order) is not claimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_n | input | 1 | Active-low transaction frame from the initiator |
| irdy_n | input | 1 | Active-low initiator ready |
| cbe_n | input | 4 | Command during address phase, active-low byte enables during data phases |
| ad_in | input | 32 | Address/data lines as seen by the target |
| bar_base | input | 12 | Upper address bits of the 1 MB window, from configuration |
| ad_out | output | 32 | Read data driven toward the bus |
| ad_oe | output | 1 | Enable for driving ad_out onto the bus |
| trdy_n | output | 1 | Active-low target ready |
| devsel_n | output | 1 | Active-low device select |
| stop_n | output | 1 | Active-low stop (retry request) |
| core_addr | output | 20 | Word-aligned byte offset inside the window |
| core_be_n | output | 4 | Active-low byte enables for the core access |
| core_wdata | output | 32 | Write data for the core |
| core_rd_start | output | 1 | One-clock read request to the core |
| core_wr_start | output | 1 | One-clock write request to the core |
| core_done | input | 1 | One-clock completion pulse from the core |
| core_rdata | input | 32 | Read data from the core, valid with core_done |

## Verification
The bench aims at the clock timing of device select and target ready. A design that decoded one clock early, or let trdy_n lag or linger after done, would fail the checks made at the exact negedge of each event. Bursts cross the top of the window, where a counter that carried past 20 bits or failed to prefetch would send the wrong core_addr. Other bursts hold irdy_n high between phases, where a sequencer that ignored initiator ready would fire an early strobe. A core slow enough to trip the abort timer, followed by its late done, catches a target that completes instead of retrying, asserts stop on the wrong clock, or reacts to the orphan done.

// File: rtl/memtgt_pkg.sv
package memtgt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_RETRY
  } tgt_state_e;

  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;

  function automatic logic cmd_is_mem(input logic [3:0] cmd);
    return (cmd == CMD_MEM_RD) || (cmd == CMD_MEM_WR);
  endfunction

  function automatic logic cmd_is_wr(input logic [3:0] cmd);
    return cmd == CMD_MEM_WR;
  endfunction

endpackage

// File: rtl/memtgt_decode.sv
module memtgt_decode import memtgt_pkg::*; #(
  parameter int AD_W = 32,
  parameter int WIN_BITS = 20,
  localparam int BASE_W = AD_W - WIN_BITS
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AD_W-1:0]     ad_in,
  input  logic [3:0]          cbe_n,
  input  logic [BASE_W-1:0]   bar_base,
  output logic                hit_q,
  output logic                wr_q,
  output logic [WIN_BITS-1:0] off_q
);

  // Match evaluated every clock; the sequencer only looks at it after an address phase.
  logic hit_spec;

  always_comb begin
    hit_spec = cmd_is_mem(cbe_n)
            && (ad_in[AD_W-1:WIN_BITS] == bar_base)
            && (ad_in[1:0] == 2'b00);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      wr_q  <= 1'b0;
      off_q <= '0;
    end else begin
      hit_q <= hit_spec;
      wr_q  <= cmd_is_wr(cbe_n);
      off_q <= {ad_in[WIN_BITS-1:2], 2'b00};
    end
  end

endmodule

// File: rtl/memtgt_burst_addr.sv
module memtgt_burst_addr #(
  parameter int WIN_BITS = 20
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [WIN_BITS-1:0] load_off,
  input  logic                adv,
  output logic [WIN_BITS-1:0] cur_off,
  output logic [WIN_BITS-1:0] nxt_off
);

  // Next word offset, wrapping inside the window.
  function automatic logic [WIN_BITS-1:0] step_off(input logic [WIN_BITS-1:0] o);
    return o + WIN_BITS'(4);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_off <= '0;
      nxt_off <= WIN_BITS'(4);
    end else if (load) begin
      cur_off <= load_off;
      nxt_off <= step_off(load_off);
    end else if (adv) begin
      cur_off <= nxt_off;
      nxt_off <= step_off(nxt_off);
    end
  end

  assert_adv_prefetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !load |=> (cur_off == $past(nxt_off)));

endmodule

// File: rtl/memtgt_abort_timer.sv
module memtgt_abort_timer #(
  parameter int ABORT_LIMIT = 16,
  localparam int CNT_W = $clog2(ABORT_LIMIT + 1)
)(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic expired
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (run && (cnt != CNT_W'(ABORT_LIMIT))) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign expired = (cnt == CNT_W'(ABORT_LIMIT));

  assert_count_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(ABORT_LIMIT));

endmodule

// File: rtl/memtgt_seq.sv
module memtgt_seq import memtgt_pkg::*; #(
  parameter int AD_W = 32,
  parameter int WIN_BITS = 20,
  parameter int ABORT_LIMIT = 16,
  localparam int BASE_W = AD_W - WIN_BITS,
  localparam int BE_W = AD_W / 8
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_n,
  input  logic                irdy_n,
  input  logic [BE_W-1:0]     cbe_n,
  input  logic [AD_W-1:0]     ad_in,
  input  logic [BASE_W-1:0]   bar_base,
  output logic [AD_W-1:0]     ad_out,
  output logic                ad_oe,
  output logic                trdy_n,
  output logic                devsel_n,
  output logic                stop_n,
  output logic [WIN_BITS-1:0] core_addr,
  output logic [BE_W-1:0]     core_be_n,
  output logic [AD_W-1:0]     core_wdata,
  output logic                core_rd_start,
  output logic                core_wr_start,
  input  logic                core_done,
  input  logic [AD_W-1:0]     core_rdata
);

  tgt_state_e st;
  logic frame_q, pend_q, first_q, is_wr_q;
  logic [AD_W-1:0] rdata_q;

  logic dec_hit, dec_wr;
  logic [WIN_BITS-1:0] dec_off, cur_off, nxt_off;
  logic tmr_expired;

  // Named internal events
  logic addr_phase, claim, xfer, last_xfer, burst_adv;
  logic done_accept, abort_fire, issue, retry_end, tmr_run;

  memtgt_decode #(.AD_W(AD_W), .WIN_BITS(WIN_BITS)) u_dec (
    .clk(clk), .rst_n(rst_n), .ad_in(ad_in), .cbe_n(cbe_n), .bar_base(bar_base),
    .hit_q(dec_hit), .wr_q(dec_wr), .off_q(dec_off)
  );

  memtgt_burst_addr #(.WIN_BITS(WIN_BITS)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(claim), .load_off(dec_off), .adv(burst_adv),
    .cur_off(cur_off), .nxt_off(nxt_off)
  );

  memtgt_abort_timer #(.ABORT_LIMIT(ABORT_LIMIT)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(claim), .run(tmr_run), .expired(tmr_expired)
  );

  assign addr_phase  = (st == ST_IDLE) && frame_q && !frame_n;
  assign claim       = (st == ST_ADDR) && dec_hit;
  assign xfer        = (st == ST_DATA) && !trdy_n && !irdy_n;
  assign last_xfer   = xfer && frame_n;
  assign burst_adv   = xfer && !frame_n;
  assign done_accept = (st == ST_DATA) && pend_q && core_done;
  assign abort_fire  = (st == ST_DATA) && !first_q && tmr_expired && trdy_n && !done_accept;
  assign issue       = (st == ST_DATA) && !pend_q && trdy_n && !irdy_n && !abort_fire;
  assign retry_end   = (st == ST_RETRY) && frame_n;
  assign tmr_run     = (st == ST_DATA) && !first_q;

  assign core_addr = cur_off;
  assign ad_out    = rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= ST_IDLE;
      frame_q       <= 1'b1;
      pend_q        <= 1'b0;
      first_q       <= 1'b0;
      is_wr_q       <= 1'b0;
      rdata_q       <= '0;
      ad_oe         <= 1'b0;
      trdy_n        <= 1'b1;
      devsel_n      <= 1'b1;
      stop_n        <= 1'b1;
      core_be_n     <= '1;
      core_wdata    <= '0;
      core_rd_start <= 1'b0;
      core_wr_start <= 1'b0;
    end else begin
      frame_q       <= frame_n;
      core_rd_start <= 1'b0;
      core_wr_start <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (addr_phase) st <= ST_ADDR;
        end
        ST_ADDR: begin
          if (claim) begin
            st       <= ST_DATA;
            devsel_n <= 1'b0;
            is_wr_q  <= dec_wr;
            ad_oe    <= !dec_wr;
            first_q  <= 1'b0;
            pend_q   <= 1'b0;
          end else begin
            st <= ST_IDLE;
          end
        end
        ST_DATA: begin
          if (last_xfer) begin
            trdy_n   <= 1'b1;
            devsel_n <= 1'b1;
            ad_oe    <= 1'b0;
            st       <= ST_IDLE;
          end else if (xfer) begin
            trdy_n  <= 1'b1;
            first_q <= 1'b1;
          end else if (done_accept) begin
            trdy_n  <= 1'b0;
            pend_q  <= 1'b0;
            rdata_q <= core_rdata;
          end else if (abort_fire) begin
            stop_n <= 1'b0;
            pend_q <= 1'b0;
            st     <= ST_RETRY;
          end else if (issue) begin
            pend_q    <= 1'b1;
            core_be_n <= cbe_n;
            if (is_wr_q) begin
              core_wr_start <= 1'b1;
              core_wdata    <= ad_in;
            end else begin
              core_rd_start <= 1'b1;
            end
          end
        end
        ST_RETRY: begin
          if (retry_end) begin
            stop_n   <= 1'b1;
            devsel_n <= 1'b1;
            ad_oe    <= 1'b0;
            st       <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_devsel_medium_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(devsel_n) |-> ($past(frame_n, 2) == 1'b0) && ($past(frame_n, 3) == 1'b1));

  assert_no_claim_on_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ADDR) && !dec_hit |=> devsel_n);

  assert_start_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({core_rd_start, core_wr_start}));

  assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rd_start || core_wr_start) |=> !(core_rd_start || core_wr_start));

  assert_trdy_after_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trdy_n) |-> $past(core_done));

  assert_trdy_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !trdy_n && !irdy_n |=> trdy_n);

  assert_trdy_claimed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !trdy_n |-> !devsel_n);

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !trdy_n && !irdy_n && frame_n |=> devsel_n);

  assert_oe_claimed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> !devsel_n);

  assert_retry_no_trdy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_n |-> trdy_n);

  assert_stop_after_timeout_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_n) |-> $past(tmr_expired));

  assert_start_irdy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rd_start || core_wr_start) |-> $past(!irdy_n));

endmodule

// File: tb/tb_memtgt_seq.sv
module tb_memtgt_seq;

  localparam int LIMIT = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_n = 1'b1, irdy_n = 1'b1;
  logic [3:0] cbe_n = 4'hF;
  logic [31:0] ad_in = '0;
  logic [11:0] bar_base = 12'hFFE;
  logic [31:0] ad_out;
  logic ad_oe, trdy_n, devsel_n, stop_n;
  logic [19:0] core_addr;
  logic [3:0] core_be_n;
  logic [31:0] core_wdata;
  logic core_rd_start, core_wr_start;
  logic core_done = 1'b0;
  logic [31:0] core_rdata = '0;

  memtgt_seq #(.ABORT_LIMIT(LIMIT)) dut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .cbe_n(cbe_n),
    .ad_in(ad_in), .bar_base(bar_base), .ad_out(ad_out), .ad_oe(ad_oe),
    .trdy_n(trdy_n), .devsel_n(devsel_n), .stop_n(stop_n), .core_addr(core_addr),
    .core_be_n(core_be_n), .core_wdata(core_wdata), .core_rd_start(core_rd_start),
    .core_wr_start(core_wr_start), .core_done(core_done), .core_rdata(core_rdata)
  );

  always #2.5ns clk = ~clk;

  int checks = 0, fails = 0;
  int cyc = 0, done_cyc = -10, core_lat = 1, busy_cnt = 0;
  logic [19:0] lat_off = '0;
  logic [31:0] wdat [8];
  logic [3:0] bes [8];

  typedef struct packed {
    logic        wr;
    logic [19:0] off;
    logic [3:0]  be;
    logic [31:0] data;
  } exp_t;
  exp_t exp_q [$];

  function automatic logic [31:0] rd_pat(input logic [19:0] o);
    return {12'hA5C, o} ^ {o[7:0], 24'h0};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc++;

  // Core model: done after core_lat clocks, read data from a pattern
  always @(negedge clk) begin
    core_done = 1'b0;
    if (busy_cnt > 0) begin
      busy_cnt--;
      if (busy_cnt == 0) begin
        core_done  = 1'b1;
        core_rdata = rd_pat(lat_off);
        done_cyc   = cyc;
      end
    end
    if (core_rd_start || core_wr_start) begin
      busy_cnt = core_lat;
      lat_off  = core_addr;
    end
  end

  // Scoreboard monitor
  always @(negedge clk) begin : mon
    exp_t e;
    if (rst_n && (core_rd_start || core_wr_start)) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4", "unexpected core strobe", {12'h0, core_addr}, 32'h0);
      end else begin
        e = exp_q.pop_front();
        chk(core_wr_start == e.wr, "R4", "strobe kind", {31'h0, core_wr_start}, {31'h0, e.wr});
        chk(core_addr == e.off, "R6", "core offset", {12'h0, core_addr}, {12'h0, e.off});
        chk(core_be_n == e.be, "R4", "byte enables", {28'h0, core_be_n}, {28'h0, e.be});
        if (e.wr) chk(core_wdata == e.data, "R4", "write data", core_wdata, e.data);
      end
    end
  end

  task automatic run_txn(input bit wr, input logic [3:0] cmd, input logic [31:0] addr,
                         input int n, input int gap, input bit claim_exp, input bit retry_exp);
    bit stopped;
    int g, dev_cyc;
    logic [19:0] off;
    stopped = 1'b0;
    if (claim_exp) begin
      for (int i = 0; i < (retry_exp ? 1 : n); i++) begin
        off = addr[19:0] + 20'(4 * i);
        exp_q.push_back('{wr: wr, off: off, be: bes[i], data: (wr ? wdat[i] : 32'h0)});
      end
    end
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; ad_in = addr; cbe_n = cmd;
    @(negedge clk);
    chk(devsel_n == 1'b1, "R2", "devsel one clock after address", {31'h0, devsel_n}, 32'h1);
    if (!wr) chk(ad_oe == 1'b0, "R8", "turnaround clock", {31'h0, ad_oe}, 32'h0);
    frame_n = (n == 1); irdy_n = 1'b0; cbe_n = bes[0]; ad_in = wr ? wdat[0] : 32'h0;
    @(negedge clk);
    if (!claim_exp) begin
      for (int c = 0; c < 5; c++) begin
        chk(devsel_n && trdy_n, "R3", "unclaimed stays quiet", {30'h0, devsel_n, trdy_n}, 32'h3);
        @(negedge clk);
      end
      frame_n = 1'b1;
      @(negedge clk);
      irdy_n = 1'b1;
      return;
    end
    dev_cyc = cyc;
    chk(devsel_n == 1'b0, "R2", "devsel two clocks after address", {31'h0, devsel_n}, 32'h0);
    chk(ad_oe == !wr, "R8", "drive enable after turnaround", {31'h0, ad_oe}, {31'h0, !wr});
    for (int i = 0; i < n; i++) begin
      off = addr[19:0] + 20'(4 * i);
      if (i > 0) begin
        if (gap > 0) begin
          irdy_n = 1'b1;
          for (int k = 0; k < gap; k++) begin
            @(negedge clk);
            chk(!(core_rd_start || core_wr_start), "R11", "strobe while irdy high",
                {30'h0, core_rd_start, core_wr_start}, 32'h0);
          end
        end
        irdy_n = 1'b0; frame_n = (i == n - 1); cbe_n = bes[i]; ad_in = wr ? wdat[i] : 32'h0;
      end
      g = 0;
      while (trdy_n && stop_n && g < 300) begin
        @(negedge clk);
        g++;
      end
      if (!stop_n) begin
        stopped = 1'b1;
        chk(trdy_n == 1'b1, "R9", "stop without trdy", {31'h0, trdy_n}, 32'h1);
        chk(cyc - dev_cyc == LIMIT + 1, "R9", "stop timing", 32'(cyc - dev_cyc), 32'(LIMIT + 1));
        frame_n = 1'b1;
        @(negedge clk);
        chk(stop_n && devsel_n, "R9", "release after frame high", {30'h0, stop_n, devsel_n}, 32'h3);
        irdy_n = 1'b1;
        break;
      end
      if (trdy_n) begin
        chk(1'b0, "R5", "trdy never asserted", {31'h0, trdy_n}, 32'h0);
        break;
      end
      chk(cyc == done_cyc + 1, "R5", "trdy one clock after done", 32'(cyc), 32'(done_cyc + 1));
      if (!wr) begin
        chk(ad_out == rd_pat(off), "R5", "read data on bus", ad_out, rd_pat(off));
        chk(ad_oe == 1'b1, "R8", "driving during read", {31'h0, ad_oe}, 32'h1);
      end
      @(negedge clk);
      chk(trdy_n == 1'b1, "R5", "trdy single clock", {31'h0, trdy_n}, 32'h1);
      if (i == n - 1) begin
        irdy_n = 1'b1;
        chk(devsel_n == 1'b1, "R7", "released at end", {31'h0, devsel_n}, 32'h1);
        chk(ad_oe == 1'b0, "R8", "drive off at end", {31'h0, ad_oe}, 32'h0);
      end
    end
    chk(stopped == retry_exp, "R9", "retry outcome", {31'h0, stopped}, {31'h0, retry_exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(trdy_n && devsel_n && stop_n, "R1", "controls high in reset", {29'h0, trdy_n, devsel_n, stop_n}, 32'h7);
    chk(!ad_oe && !core_rd_start && !core_wr_start, "R1", "no drive in reset",
        {29'h0, ad_oe, core_rd_start, core_wr_start}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(trdy_n && devsel_n && stop_n, "R1", "controls high after reset", {29'h0, trdy_n, devsel_n, stop_n}, 32'h7);

    for (int i = 0; i < 8; i++) begin
      wdat[i] = 32'h1000_0001 * (i + 3) ^ 32'h00FF_00F0;
      bes[i]  = 4'(i * 5);
    end

    // R2 R4 R5 R7: single write
    core_lat = 1;
    run_txn(1'b1, 4'b0111, 32'hFFE0_0040, 1, 0, 1'b1, 1'b0);
    // R5 R8: single read with latency 3
    core_lat = 3;
    run_txn(1'b0, 4'b0110, 32'hFFE1_2340, 1, 0, 1'b1, 1'b0);
    // R6 R11: write burst with initiator wait states
    core_lat = 2;
    run_txn(1'b1, 4'b0111, 32'hFFE0_0100, 4, 2, 1'b1, 1'b0);
    // R6: read burst wrapping at the top of the window
    core_lat = 1;
    run_txn(1'b0, 4'b0110, 32'hFFEF_FFF8, 3, 0, 1'b1, 1'b0);
    // R3: address outside window, and non-memory command inside it
    run_txn(1'b1, 4'b0111, 32'hFFD0_0000, 1, 0, 1'b0, 1'b0);
    run_txn(1'b1, 4'b0011, 32'hFFE0_0000, 1, 0, 1'b0, 1'b0);
    // R12: non-linear burst order bits
    run_txn(1'b0, 4'b0110, 32'hFFE0_0011, 1, 0, 1'b0, 1'b0);
    // R9 negative: slow core under the limit completes normally
    core_lat = 10;
    run_txn(1'b0, 4'b0110, 32'hFFE0_0800, 1, 0, 1'b1, 1'b0);
    // R9: core too slow, retry
    core_lat = 60;
    run_txn(1'b0, 4'b0110, 32'hFFE0_0900, 2, 0, 1'b1, 1'b1);
    // R10: the late done arrives while idle and must not disturb the bus
    for (int c = 0; c < 70; c++) begin
      @(negedge clk);
      if (!(trdy_n && devsel_n && stop_n))
        chk(1'b0, "R10", "stray done moved a control", {29'h0, trdy_n, devsel_n, stop_n}, 32'h7);
    end
    chk(trdy_n && devsel_n && stop_n, "R10", "quiet after stray done", {29'h0, trdy_n, devsel_n, stop_n}, 32'h7);
    // R7: a new transaction is accepted after the retry
    core_lat = 1;
    run_txn(1'b1, 4'b0111, 32'hFFE0_0A00, 2, 1, 1'b1, 1'b0);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R4", "all expected core accesses seen", 32'(exp_q.size()), 32'h0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule